// File: doc/BRIEF.md
# Receive Descriptor Ring Writeback Engine

This block walks a ring of receive descriptors that sit in a small on-chip descriptor memory. Software fills each descriptor through a word-wide configuration port. It sets the ownership bit to give a descriptor to the engine. When the run input is high, the engine reads the descriptor at the current ring position. If the engine owns it, the engine accepts one frame from a simple byte stream, in which each accepted beat carries one byte. It then writes a status word back into the descriptor, which also clears ownership, and moves to the next position.

When the engine finds a descriptor that software still holds, it suspends. A poll-demand pulse makes it read the same descriptor again. A bit in the size word marks the end of the ring. Dropping run stops the engine once any frame already under way has been written back. The ring position then returns to descriptor 0.

Descriptors are `DESC_WORDS` (8) words long. Word `w` of descriptor `d` sits at address `d*DESC_WORDS + w`. Word 0 holds ownership and status. Word 1 holds the two buffer sizes and the end-of-ring mark. The remaining words are left to software.

Top module: `rxr_ring_engine`

## Requirements
- R1: After reset, ring_idx is 0, ring_suspended is 0, rx_ready is 0 and every descriptor memory word reads 0.
- R2: With rx_run high, a descriptor whose word 0 has bit 31 set is fetched and rx_ready rises. Each beat with rx_valid and rx_ready counts one byte. The beat with rx_last ends the frame.
- R3: A fetched descriptor with word 0 bit 31 clear puts the engine in suspension. In suspension ring_suspended is 1, rx_ready is 0 and ring_idx does not change until a poll demand arrives.
- R4: A poll_dmd pulse during suspension re-reads the same descriptor and resumes if it is now owned. A poll_dmd that coincides with the fetch that causes suspension is remembered, so the engine re-reads at once.
- R5: The writeback replaces word 0 with bit 31 = 0, bits 29:16 = stored byte count, bit 9 = 1 and bit 8 = 1, plus the error bits of R6 and R7; every other bit is 0. Words 1 to 7 are not written.
- R6: The capacity is word 1 bits 12:0 plus word 1 bits 28:16. Bytes beyond the capacity are dropped: the length field equals the capacity, and bit 11 and bit 15 are set.
- R7: If any beat of a frame has rx_crc_err high, bits 1 and 15 of the writeback are set.
- R8: After a writeback the ring index advances by one. It returns to 0 after a descriptor whose word 1 bit 15 is set, or after descriptor NUM_DESC-1.
- R9: Clearing rx_run lets a frame that has already received a beat finish and be written back. After that no further descriptor is touched and ring_idx reads 0. Setting rx_run again starts at descriptor 0.
- R10: If a configuration write hits the same word in the cycle the engine writes back, the engine's word is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_run | input | 1 | Engine enable |
| poll_dmd | input | 1 | Poll-demand pulse |
| cfg_we | input | 1 | Descriptor memory write strobe |
| cfg_addr | input | AW (5) | Descriptor memory word address |
| cfg_wdata | input | 32 | Descriptor memory write data |
| cfg_rdata | output | 32 | Descriptor memory read data at cfg_addr (combinational) |
| rx_valid | input | 1 | Stream beat valid |
| rx_last | input | 1 | Final beat of the frame |
| rx_crc_err | input | 1 | Beat carries a receive error |
| rx_ready | output | 1 | Engine accepts a beat |
| ring_idx | output | IDX_W (2) | Current ring position |
| ring_suspended | output | 1 | Engine waits for a poll demand |

## Verification
The engine's status writeback and a software write to the same word 0 can fall in one cycle. The bench provokes this by holding a configuration write through the clock edge that follows the last beat of a frame. It judges the result by reading the word back: the status value must be there, not the software data. A second same-cycle case is also exercised: a poll pulse is placed exactly on the fetch that finds a software-held descriptor. The bench then judges whether rx_ready rises two cycles later without any further poll.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_FETCH, ST_SUSP, ST_RECV, ST_WB} rxr_state_e;

  localparam int OWN_BIT   = 31;
  localparam int EOR_BIT   = 15;
  localparam int FIRST_BIT = 9;
  localparam int LAST_BIT  = 8;
  localparam int OVF_BIT   = 11;
  localparam int CRC_BIT   = 1;
  localparam int SUM_BIT   = 15;
  localparam int LEN_LSB   = 16;
  localparam int LEN_W     = 14;
  localparam int BSZ_W     = 13;
  localparam int BUF2_LSB  = 16;

  // total space of both buffers named by a size word
  function automatic logic [LEN_W-1:0] f_capacity(input logic [31:0] sz);
    return LEN_W'(sz[BSZ_W-1:0]) + LEN_W'(sz[BUF2_LSB +: BSZ_W]);
  endfunction

  function automatic logic f_owned(input logic [31:0] w0);
    return w0[OWN_BIT];
  endfunction

  function automatic logic f_end_mark(input logic [31:0] sz);
    return sz[EOR_BIT];
  endfunction

  // status word written over word 0 when a frame completes
  function automatic logic [31:0] f_wb_word(input logic [LEN_W-1:0] len,
                                            input logic crc, input logic ovf);
    logic [31:0] w;
    w = '0;
    w[LEN_LSB +: LEN_W] = len;
    w[FIRST_BIT] = 1'b1;
    w[LAST_BIT]  = 1'b1;
    w[OVF_BIT]   = ovf;
    w[CRC_BIT]   = crc;
    w[SUM_BIT]   = crc | ovf;
    w[OWN_BIT]   = 1'b0;
    return w;
  endfunction
endpackage

// File: rtl/rxr_desc_mem.sv
module rxr_desc_mem #(
  parameter int AW     = 5,
  parameter int IDX_W  = 2,
  parameter int WSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [AW-1:0]     sw_addr,
  input  logic [31:0]       sw_wdata,
  output logic [31:0]       sw_rdata,
  input  logic              eng_we,
  input  logic [AW-1:0]     eng_addr,
  input  logic [31:0]       eng_wdata,
  input  logic [IDX_W-1:0]  fetch_idx,
  output logic [31:0]       fetch_w0,
  output logic [31:0]       fetch_w1
);
  localparam int DEPTH = 1 << AW;

  logic [31:0] mem [DEPTH];
  logic [AW-1:0] base0, base1;

  assign base0    = {fetch_idx, WSEL_W'(0)};
  assign base1    = {fetch_idx, WSEL_W'(1)};
  assign fetch_w0 = mem[base0];
  assign fetch_w1 = mem[base1];
  assign sw_rdata = mem[sw_addr];

  // engine write takes the word when both ports aim at it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (eng_we && eng_addr == AW'(i))     mem[i] <= eng_wdata;
        else if (sw_we && sw_addr == AW'(i))  mem[i] <= sw_wdata;
      end
    end
  end
endmodule

// File: rtl/rxr_frame_acc.sv
module rxr_frame_acc #(
  parameter int LEN_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             beat,
  input  logic             beat_err,
  input  logic [LEN_W-1:0] cap,
  output logic [LEN_W-1:0] len,
  output logic             crc,
  output logic             ovf
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len <= '0;
      crc <= 1'b0;
      ovf <= 1'b0;
    end else if (clear) begin
      len <= '0;
      crc <= 1'b0;
      ovf <= 1'b0;
    end else if (beat) begin
      if (len < cap) len <= len + 1'b1;
      else           ovf <= 1'b1;
      if (beat_err)  crc <= 1'b1;
    end
  end
endmodule

// File: rtl/rxr_ring_ctrl.sv
module rxr_ring_ctrl
  import rxr_pkg::*;
#(
  parameter int NUM_DESC = 4,
  parameter int IDX_W    = 2,
  parameter int CAP_W    = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             poll,
  input  logic             w0_own,
  input  logic             w1_eor,
  input  logic [CAP_W-1:0] w1_cap,
  input  logic             s_valid,
  input  logic             s_last,
  output logic [IDX_W-1:0] idx,
  output logic             ready,
  output logic             beat,
  output logic             fetch_evt,
  output logic             wb_evt,
  output logic             poll_pend,
  output logic             suspended,
  output logic             idle,
  output logic             eor_q,
  output logic [CAP_W-1:0] cap_q
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DESC - 1);

  rxr_state_e st, st_nx;
  logic in_frame;
  logic [IDX_W-1:0] idx_adv;

  assign ready     = (st == ST_RECV) && (run || in_frame);
  assign beat      = ready && s_valid;
  assign fetch_evt = (st == ST_FETCH) && run;
  assign wb_evt    = (st == ST_WB);
  assign suspended = (st == ST_SUSP);
  assign idle      = (st == ST_IDLE);
  assign idx_adv   = (eor_q || idx == LAST_IDX) ? '0 : idx + 1'b1;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:  if (run) st_nx = ST_FETCH;
      ST_FETCH: if (!run) st_nx = ST_IDLE;
                else if (w0_own) st_nx = ST_RECV;
                else st_nx = ST_SUSP;
      ST_SUSP:  if (!run) st_nx = ST_IDLE;
                else if (poll_pend) st_nx = ST_FETCH;
      ST_RECV:  if (!run && !in_frame) st_nx = ST_IDLE;
                else if (beat && s_last) st_nx = ST_WB;
      ST_WB:    st_nx = run ? ST_FETCH : ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      idx       <= '0;
      in_frame  <= 1'b0;
      poll_pend <= 1'b0;
      eor_q     <= 1'b0;
      cap_q     <= '0;
    end else begin
      st        <= st_nx;
      // a demand arriving during a fetch survives that fetch
      poll_pend <= poll | (poll_pend & (st != ST_FETCH));
      if (idle)        idx <= '0;
      else if (wb_evt) idx <= idx_adv;
      if (fetch_evt) begin
        cap_q    <= w1_cap;
        eor_q    <= w1_eor;
        in_frame <= 1'b0;
      end else if (wb_evt) begin
        in_frame <= 1'b0;
      end else if (beat) begin
        in_frame <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxr_ring_engine.sv
module rxr_ring_engine
  import rxr_pkg::*;
#(
  parameter int NUM_DESC   = 4,
  parameter int DESC_WORDS = 8,
  localparam int IDX_W  = $clog2(NUM_DESC),
  localparam int WSEL_W = $clog2(DESC_WORDS),
  localparam int AW     = IDX_W + WSEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_run,
  input  logic             poll_dmd,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             rx_valid,
  input  logic             rx_last,
  input  logic             rx_crc_err,
  output logic             rx_ready,
  output logic [IDX_W-1:0] ring_idx,
  output logic             ring_suspended
);
  logic [31:0]      fetch_w0, fetch_w1, wb_word;
  logic [AW-1:0]    wb_addr;
  logic [LEN_W-1:0] cap_q, acc_len;
  logic             acc_crc, acc_ovf;
  logic             beat, fetch_evt, wb_evt, poll_pend, eng_idle, eor_q;

  assign wb_addr = {ring_idx, WSEL_W'(0)};
  assign wb_word = f_wb_word(acc_len, acc_crc, acc_ovf);

  rxr_desc_mem #(.AW(AW), .IDX_W(IDX_W), .WSEL_W(WSEL_W)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_we     (cfg_we),
    .sw_addr   (cfg_addr),
    .sw_wdata  (cfg_wdata),
    .sw_rdata  (cfg_rdata),
    .eng_we    (wb_evt),
    .eng_addr  (wb_addr),
    .eng_wdata (wb_word),
    .fetch_idx (ring_idx),
    .fetch_w0  (fetch_w0),
    .fetch_w1  (fetch_w1)
  );

  rxr_ring_ctrl #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W), .CAP_W(LEN_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (rx_run),
    .poll      (poll_dmd),
    .w0_own    (f_owned(fetch_w0)),
    .w1_eor    (f_end_mark(fetch_w1)),
    .w1_cap    (f_capacity(fetch_w1)),
    .s_valid   (rx_valid),
    .s_last    (rx_last),
    .idx       (ring_idx),
    .ready     (rx_ready),
    .beat      (beat),
    .fetch_evt (fetch_evt),
    .wb_evt    (wb_evt),
    .poll_pend (poll_pend),
    .suspended (ring_suspended),
    .idle      (eng_idle),
    .eor_q     (eor_q),
    .cap_q     (cap_q)
  );

  rxr_frame_acc #(.LEN_W(LEN_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (fetch_evt),
    .beat     (beat),
    .beat_err (rx_crc_err),
    .cap      (cap_q),
    .len      (acc_len),
    .crc      (acc_crc),
    .ovf      (acc_ovf)
  );
endmodule

// File: rtl/rxr_ring_chk.sv
module rxr_ring_chk #(
  parameter int IDX_W = 2,
  parameter int LEN_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_run,
  input logic             rx_ready,
  input logic             ring_suspended,
  input logic [IDX_W-1:0] ring_idx,
  input logic             poll_pend,
  input logic             fetch_evt,
  input logic             wb_evt,
  input logic             beat,
  input logic             eng_idle,
  input logic             wb_eor,
  input logic [LEN_W-1:0] wb_len,
  input logic [LEN_W-1:0] wb_cap,
  input logic             wb_ovf
);
  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fetch_evt, wb_evt, beat})); // R2

  AST_NO_READY_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
    ring_suspended |-> !rx_ready); // R3

  AST_SUSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_suspended && !poll_pend && rx_run) |=> (ring_suspended && $stable(ring_idx))); // R3

  AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    wb_evt |-> (wb_len <= wb_cap)); // R6

  AST_OVF_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_evt && wb_ovf) |-> (wb_len == wb_cap)); // R6

  AST_EOR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_evt && wb_eor) |=> (ring_idx == '0)); // R8

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_evt && $past(eng_idle)) |-> (ring_idx == '0)); // R9
endmodule

bind rxr_ring_engine rxr_ring_chk #(.IDX_W(IDX_W), .LEN_W(rxr_pkg::LEN_W)) u_rxr_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .rx_run         (rx_run),
  .rx_ready       (rx_ready),
  .ring_suspended (ring_suspended),
  .ring_idx       (ring_idx),
  .poll_pend      (poll_pend),
  .fetch_evt      (fetch_evt),
  .wb_evt         (wb_evt),
  .beat           (beat),
  .eng_idle       (eng_idle),
  .wb_eor         (eor_q),
  .wb_len         (acc_len),
  .wb_cap         (cap_q),
  .wb_ovf         (acc_ovf)
);

// File: tb/test_rxr_ring_engine.sv
module test_rxr_ring_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;
  localparam int TB_BEATS [NT] = '{5, 10, 3, 1};
  localparam int TB_B1    [NT] = '{8, 4, 2, 0};
  localparam int TB_B2    [NT] = '{0, 4, 6, 0};
  localparam int TB_ERR   [NT] = '{-1, -1, 1, -1};
  localparam logic [31:0] TB_EXP [NT] =
    '{32'h0005_0300, 32'h0008_8B00, 32'h0003_8302, 32'h0000_8B00};

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_run = 1'b0, poll_dmd = 1'b0, cfg_we = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic rx_valid = 1'b0, rx_last = 1'b0, rx_crc_err = 1'b0;
  logic rx_ready, ring_suspended;
  logic [1:0] ring_idx;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxr_ring_engine i_rxr_ring_engine (
    .clk(clk), .rst_n(rst_n), .rx_run(rx_run), .poll_dmd(poll_dmd),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .rx_valid(rx_valid), .rx_last(rx_last), .rx_crc_err(rx_crc_err), .rx_ready(rx_ready),
    .ring_idx(ring_idx), .ring_suspended(ring_suspended)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int d, input int w, input logic [31:0] data);
    cfg_we = 1'b1; cfg_addr = 5'(d*8 + w); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input int d, input int w, output logic [31:0] data);
    cfg_addr = 5'(d*8 + w);
    #1 data = cfg_rdata;
  endtask

  task automatic pulse_poll();
    poll_dmd = 1'b1;
    @(negedge clk);
    poll_dmd = 1'b0;
  endtask

  task automatic send_beat(input logic last, input logic err);
    rx_valid = 1'b1; rx_last = last; rx_crc_err = err;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; rx_crc_err = 1'b0;
  endtask

  task automatic send_frame(input int n, input int errb);
    for (int i = 0; i < n; i++) send_beat(i == n-1, i == errb);
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, run hung");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ring_idx", 32'(ring_idx), 0);
    chk("R1 suspended", 32'(ring_suspended), 0);
    chk("R1 ready", 32'(rx_ready), 0);
    rd(0, 0, v); chk("R1 memory word", v, 0);

    // table pass: one descriptor per vector, wrap by slot count
    for (int i = 0; i < NT; i++) begin
      wr(i, 1, (32'(TB_B2[i]) << 16) | 32'(TB_B1[i]));
      wr(i, 0, 32'h8000_0000);
    end
    rx_run = 1'b1;
    wait_n(2);
    chk("R2 ready after owned fetch", 32'(rx_ready), 1);
    for (int i = 0; i < NT; i++) begin
      send_frame(TB_BEATS[i], TB_ERR[i]);
      @(negedge clk);
      rd(i, 0, v);
      chk($sformatf("R5 R6 R7 table writeback %0d", i), v, TB_EXP[i]);
    end
    wait_n(2);
    chk("R8 wrap after last slot", 32'(ring_idx), 0);
    chk("R3 suspended on software-held", 32'(ring_suspended), 1);
    chk("R3 ready low while suspended", 32'(rx_ready), 0);
    wait_n(5);
    chk("R3 still suspended", 32'(ring_suspended), 1);
    pulse_poll();
    wait_n(4);
    chk("R4 poll re-read still not owned", 32'(ring_suspended), 1);
    chk("R3 index unchanged", 32'(ring_idx), 0);

    // end-of-ring mark on descriptor 0
    wr(0, 1, 32'h0000_8010);
    wr(0, 0, 32'h8000_0000);
    pulse_poll();
    send_frame(4, -1);
    @(negedge clk);
    rd(0, 0, v); chk("R5 writeback len 4", v, 32'h0004_0300);
    rd(0, 1, v); chk("R5 size word untouched", v, 32'h0000_8010);
    wait_n(2);
    chk("R8 end mark wraps to 0", 32'(ring_idx), 0);
    chk("R8 suspended at base", 32'(ring_suspended), 1);

    // poll placed on the fetch that suspends
    poll_dmd = 1'b1;
    @(negedge clk);
    poll_dmd = 1'b0;
    @(negedge clk);
    chk("R4 fetch in progress", 32'(ring_suspended), 0);
    poll_dmd = 1'b1;
    @(negedge clk);
    poll_dmd = 1'b0;
    chk("R4 suspended after fetch", 32'(ring_suspended), 1);
    wr(0, 0, 32'h8000_0000);
    @(negedge clk);
    chk("R4 coincident poll remembered", 32'(rx_ready), 1);
    send_frame(2, -1);
    @(negedge clk);
    rd(0, 0, v); chk("R5 writeback len 2", v, 32'h0002_0300);
    wait_n(2);

    // run cleared mid-frame
    wr(0, 1, 32'h0000_0010); wr(0, 0, 32'h8000_0000);
    wr(1, 1, 32'h0000_0010); wr(1, 0, 32'h8000_0000);
    wr(2, 1, 32'h0000_0010); wr(2, 0, 32'h8000_0000);
    pulse_poll();
    send_frame(2, -1);
    @(negedge clk);
    rd(0, 0, v); chk("R5 desc0 writeback", v, 32'h0002_0300);
    send_beat(1'b0, 1'b0);
    rx_run = 1'b0;
    send_beat(1'b0, 1'b0);
    send_beat(1'b1, 1'b0);
    wait_n(3);
    rd(1, 0, v); chk("R9 frame finished after run low", v, 32'h0003_0300);
    rd(2, 0, v); chk("R9 next descriptor untouched", v, 32'h8000_0000);
    chk("R9 index back to 0", 32'(ring_idx), 0);
    chk("R9 ready low when halted", 32'(rx_ready), 0);
    rx_run = 1'b1;
    wait_n(3);
    chk("R9 restart at descriptor 0", 32'(ring_idx), 0);
    chk("R9 restart fetched descriptor 0", 32'(ring_suspended), 1);

    // software write collides with writeback
    wr(0, 0, 32'h8000_0000);
    pulse_poll();
    send_beat(1'b1, 1'b0);
    wr(0, 0, 32'h8000_00FF);
    rd(0, 0, v); chk("R10 engine word kept", v, 32'h0001_0300);
    wait_n(2);
    chk("R8 advanced to descriptor 1", 32'(ring_idx), 1);
    chk("R3 suspended at descriptor 1", 32'(ring_suspended), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule